// File: doc/BRIEF.md
# Compare/Test Flag Unit with Branch Condition Decoder

This block carries out the two flag-only operations of a processor's compare path. The first is a compare, which forms A minus B. The second is a test, which forms A AND B. Neither operation keeps its result. Each one only loads four registered condition flags: zero (Z), carry (C), sign (S) and overflow (V). The flags load on the clock edge that samples the strobe and hold their value at all other times.

A second, combinational path takes a 5-bit condition selector and reports at once whether a conditional branch is taken, based on the flags as they stand. The selector covers three groups: tests of a single flag, unsigned relations after a compare, and signed relations after a compare. Selector values outside those groups never take the branch. Updating the program counter is left to the block that consumes the decision.

Top module: `cmpFlagBranch`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, all four flags read 0.
- R2: A high `cmpStrobe` at a rising edge loads the flags from A-B taken modulo 2^W. Z is 1 when A equals B. S is the top bit of the difference.
- R3: On a compare, C is 1 exactly when A >= B as unsigned numbers, meaning no borrow. V is 1 exactly when the signed difference A-B falls outside the range of a W-bit signed number.
- R4: A high `tstStrobe` at a rising edge, with `cmpStrobe` low, sets Z when A AND B is zero and sets S to the top bit of A AND B. It clears both C and V.
- R5: At an edge where both strobes are low, all four flags keep their previous values, whatever the operands do.
- R6: When both strobes are high at the same edge, the compare takes priority and the flags follow R2 and R3.
- R7: The flag-test selector codes are 0 for Z=1, 1 for Z=0, 2 for C=1, 3 for C=0, 4 for S=0, 5 for S=1, 6 for V=1 and 7 for V=0. Codes 0 and 1 also serve as equal and not-equal after a compare.
- R8: The unsigned selector codes are 8 for higher (C=1 and Z=0), 9 for higher-or-equal (C=1), 10 for lower (C=0) and 11 for lower-or-equal (C=0 or Z=1).
- R9: The signed selector codes are 12 for greater (S^V=0 and Z=0), 13 for greater-or-equal (S^V=0), 14 for less (S^V=1) and 15 for less-or-equal (S^V=1 or Z=1).
- R10: Selector codes 16 to 31 never assert `takeBranch`. For every code, `takeBranch` follows the current flags and `condSel` combinationally, with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpStrobe | input | 1 | Compare request (A-B, flags only) |
| tstStrobe | input | 1 | Test request (A AND B, flags only) |
| opA | input | W | First operand |
| opB | input | W | Second operand |
| condSel | input | 5 | Branch condition selector |
| takeBranch | output | 1 | Branch decision from current flags |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry / no-borrow flag |
| flagS | output | 1 | Sign flag |
| flagV | output | 1 | Overflow flag |

## Verification
The bench chooses operand pairs at the signed-overflow boundary, such as 0x80-0x01 and 0x7F-0xFF. On these pairs a design that took V from the carry, or that tested less-than with S alone, would give the wrong signed decision while the unsigned decisions stayed correct. Equal operands expose a higher or greater condition that forgets to test Z. A test run after a compare that left C set catches a design that fails to clear C and V. Two further checks cover the remaining cases. Raising both strobes at once catches a design that lets the test win. Sweeping the selector through 16 to 31 catches a decoder that wraps those codes back onto the defined ones.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

  localparam int CondW = 5;

  typedef struct packed {
    logic z;
    logic c;
    logic s;
    logic v;
  } flags_t;

  typedef struct packed {
    logic loadCmp;
    logic loadTst;
  } ctl_t;

  typedef enum logic [CondW-1:0] {
    CC_ZSET  = 5'd0,
    CC_ZCLR  = 5'd1,
    CC_CSET  = 5'd2,
    CC_CCLR  = 5'd3,
    CC_PLUS  = 5'd4,
    CC_MINUS = 5'd5,
    CC_VSET  = 5'd6,
    CC_VCLR  = 5'd7,
    CC_UHI   = 5'd8,
    CC_UHE   = 5'd9,
    CC_ULO   = 5'd10,
    CC_ULE   = 5'd11,
    CC_SGT   = 5'd12,
    CC_SGE   = 5'd13,
    CC_SLT   = 5'd14,
    CC_SLE   = 5'd15
  } cond_e;

endpackage

// File: rtl/cfbControl.sv
module cfbControl (
  input  logic           cmpStrobe,
  input  logic           tstStrobe,
  output cfb_pkg::ctl_t  ctl
);
  // Compare wins when both strobes arrive together.
  always_comb begin
    ctl.loadCmp = cmpStrobe;
    ctl.loadTst = tstStrobe & ~cmpStrobe;
  end
endmodule

// File: rtl/cfbDatapath.sv
module cfbDatapath #(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  cfb_pkg::ctl_t   ctl,
  input  logic [W-1:0]    opA,
  input  logic [W-1:0]    opB,
  output cfb_pkg::flags_t flags
);
  localparam int MsbIdx = W - 1;

  logic [W:0]      diffExt;
  logic [W-1:0]    andRes;
  cfb_pkg::flags_t cmpFlags;
  cfb_pkg::flags_t tstFlags;

  always_comb begin
    diffExt    = {1'b0, opA} - {1'b0, opB};
    andRes     = opA & opB;
    cmpFlags.z = (diffExt[W-1:0] == '0);
    cmpFlags.c = ~diffExt[W];
    cmpFlags.s = diffExt[MsbIdx];
    cmpFlags.v = (opA[MsbIdx] != opB[MsbIdx]) && (diffExt[MsbIdx] != opA[MsbIdx]);
    tstFlags.z = (andRes == '0);
    tstFlags.c = 1'b0;
    tstFlags.s = andRes[MsbIdx];
    tstFlags.v = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            flags <= '0;
    else if (ctl.loadCmp) flags <= cmpFlags;
    else if (ctl.loadTst) flags <= tstFlags;
  end
endmodule

// File: rtl/cfbBranchDecode.sv
module cfbBranchDecode (
  input  logic [cfb_pkg::CondW-1:0] condSel,
  input  cfb_pkg::flags_t           flags,
  output logic                      takeBranch
);
  import cfb_pkg::*;

  logic sxv;

  always_comb begin
    sxv = flags.s ^ flags.v;
    unique case (condSel)
      CC_ZSET:  takeBranch = flags.z;
      CC_ZCLR:  takeBranch = ~flags.z;
      CC_CSET:  takeBranch = flags.c;
      CC_CCLR:  takeBranch = ~flags.c;
      CC_PLUS:  takeBranch = ~flags.s;
      CC_MINUS: takeBranch = flags.s;
      CC_VSET:  takeBranch = flags.v;
      CC_VCLR:  takeBranch = ~flags.v;
      CC_UHI:   takeBranch = flags.c & ~flags.z;
      CC_UHE:   takeBranch = flags.c;
      CC_ULO:   takeBranch = ~flags.c;
      CC_ULE:   takeBranch = ~flags.c | flags.z;
      CC_SGT:   takeBranch = ~sxv & ~flags.z;
      CC_SGE:   takeBranch = ~sxv;
      CC_SLT:   takeBranch = sxv;
      CC_SLE:   takeBranch = sxv | flags.z;
      default:  takeBranch = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmpFlagBranch.sv
module cmpFlagBranch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmpStrobe,
  input  logic         tstStrobe,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [4:0]   condSel,
  output logic         takeBranch,
  output logic         flagZ,
  output logic         flagC,
  output logic         flagS,
  output logic         flagV
);
  cfb_pkg::ctl_t   ctl;
  cfb_pkg::flags_t flags;

  cfbControl u_ctl (
    .cmpStrobe (cmpStrobe),
    .tstStrobe (tstStrobe),
    .ctl       (ctl)
  );

  cfbDatapath #(.W(W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .opA   (opA),
    .opB   (opB),
    .flags (flags)
  );

  cfbBranchDecode u_dec (
    .condSel    (condSel),
    .flags      (flags),
    .takeBranch (takeBranch)
  );

  assign flagZ = flags.z;
  assign flagC = flags.c;
  assign flagS = flags.s;
  assign flagV = flags.v;
endmodule

// File: rtl/cfbChecker.sv
module cfbChecker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         cmpStrobe,
  input logic         tstStrobe,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [4:0]   condSel,
  input logic         takeBranch,
  input logic         flagZ,
  input logic         flagC,
  input logic         flagS,
  input logic         flagV
);
  p_cmp_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmpStrobe |=> flagZ == ($past(opA) == $past(opB)));

  p_cmp_carry_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmpStrobe |=> flagC == ($past(opA) >= $past(opB)));

  p_tst_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tstStrobe && !cmpStrobe) |=> (!flagC && !flagV));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cmpStrobe && !tstStrobe) |=> ($stable(flagZ) && $stable(flagC) && $stable(flagS) && $stable(flagV)));

  p_unused_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    condSel[4] |-> !takeBranch);
endmodule

bind cmpFlagBranch cfbChecker #(.W(W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmpStrobe  (cmpStrobe),
  .tstStrobe  (tstStrobe),
  .opA        (opA),
  .opB        (opB),
  .condSel    (condSel),
  .takeBranch (takeBranch),
  .flagZ      (flagZ),
  .flagC      (flagC),
  .flagS      (flagS),
  .flagV      (flagV)
);

// File: tb/cmpFlagBranch_tb.sv
module cmpFlagBranch_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic         cmpStrobe;
  logic         tstStrobe;
  logic [W-1:0] opA;
  logic [W-1:0] opB;
  logic [4:0]   condSel;
  logic         takeBranch;
  logic         flagZ, flagC, flagS, flagV;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmpFlagBranch #(.W(W)) u_dut (
    .clk(clk), .rstN(rstN), .cmpStrobe(cmpStrobe), .tstStrobe(tstStrobe),
    .opA(opA), .opB(opB), .condSel(condSel), .takeBranch(takeBranch),
    .flagZ(flagZ), .flagC(flagC), .flagS(flagS), .flagV(flagV)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkFlags(input string req, input bit z, input bit c, input bit s, input bit v);
    chk(req, {28'd0, flagZ, flagC, flagS, flagV}, {28'd0, z, c, s, v});
  endtask

  // Flag-test selectors 0..7 (R7) and unused 16..31 (R10), against given flags.
  task automatic sweepFlagCodes(input bit z, input bit c, input bit s, input bit v);
    bit exp8 [8];
    exp8 = '{z, !z, c, !c, !s, s, v, !v};
    for (int k = 0; k < 8; k++) begin
      condSel = 5'(k); #1;
      chk($sformatf("R7 code %0d", k), {31'd0, takeBranch}, {31'd0, exp8[k]});
    end
    for (int k = 16; k < 32; k++) begin
      condSel = 5'(k); #1;
      chk($sformatf("R10 code %0d", k), {31'd0, takeBranch}, 32'd0);
    end
  endtask

  // Relations after a compare of a and b (R8 unsigned, R9 signed).
  task automatic sweepRelations(input logic [W-1:0] a, input logic [W-1:0] b);
    int sa, sb;
    bit exp8 [8];
    sa = $signed(a);
    sb = $signed(b);
    exp8 = '{a > b, a >= b, a < b, a <= b, sa > sb, sa >= sb, sa < sb, sa <= sb};
    for (int k = 0; k < 8; k++) begin
      condSel = 5'(k + 8); #1;
      chk($sformatf("%s code %0d a=%0h b=%0h", (k < 4) ? "R8" : "R9", k + 8, a, b),
          {31'd0, takeBranch}, {31'd0, exp8[k]});
    end
  endtask

  task automatic runCmp(input logic [W-1:0] a, input logic [W-1:0] b);
    int sd;
    bit ez, ec, es, ev;
    @(negedge clk);
    opA = a; opB = b; cmpStrobe = 1'b1;
    @(negedge clk);
    cmpStrobe = 1'b0;
    sd = $signed(a) - $signed(b);
    ez = (a == b);
    ec = (a >= b);
    es = ((int'(a) - int'(b)) & 32'h80) != 0;
    ev = (sd > 127) || (sd < -128);
    chkFlags($sformatf("R2/R3 cmp a=%0h b=%0h", a, b), ez, ec, es, ev);
    sweepFlagCodes(ez, ec, es, ev);
    sweepRelations(a, b);
  endtask

  task automatic runTst(input logic [W-1:0] a, input logic [W-1:0] b);
    bit ez, es;
    @(negedge clk);
    opA = a; opB = b; tstStrobe = 1'b1;
    @(negedge clk);
    tstStrobe = 1'b0;
    ez = ((a & b) == 0);
    es = ((a & b) >= 8'h80);
    chkFlags($sformatf("R4 tst a=%0h b=%0h", a, b), ez, 1'b0, es, 1'b0);
    sweepFlagCodes(ez, 1'b0, es, 1'b0);
  endtask

  task automatic runHold();
    @(negedge clk);
    opA = 8'h10; opB = 8'h20; cmpStrobe = 1'b1;
    @(negedge clk);
    cmpStrobe = 1'b0;
    for (int k = 0; k < 4; k++) begin
      opA = 8'(k * 37); opB = 8'(255 - k);
      @(negedge clk);
      chkFlags("R5 hold without strobe", 1'b0, 1'b0, 1'b1, 1'b0);
    end
  endtask

  task automatic runBoth();
    @(negedge clk);
    opA = 8'h03; opB = 8'h03; cmpStrobe = 1'b1; tstStrobe = 1'b1;
    @(negedge clk);
    cmpStrobe = 1'b0; tstStrobe = 1'b0;
    chkFlags("R6 compare wins over test", 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    rstN = 1'b0; cmpStrobe = 1'b0; tstStrobe = 1'b0;
    opA = '0; opB = '0; condSel = '0;
    repeat (3) @(negedge clk);
    chkFlags("R1 flags in reset", 1'b0, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chkFlags("R1 flags after reset", 1'b0, 1'b0, 1'b0, 1'b0);

    runCmp(8'h05, 8'h05);
    runCmp(8'h03, 8'h07);
    runCmp(8'h07, 8'h03);
    runCmp(8'h80, 8'h01);
    runCmp(8'h7F, 8'hFF);
    runCmp(8'h00, 8'h00);
    runCmp(8'hFF, 8'h00);
    runCmp(8'h01, 8'h80);
    runCmp(8'hFE, 8'hFF);
    runTst(8'hF0, 8'h0F);
    runCmp(8'h90, 8'h10);
    runTst(8'h80, 8'hFF);
    runTst(8'h3C, 8'h14);
    runHold();
    runBoth();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule